// File: doc/BRIEF.md
# DDR Interleaved I/Q DAC Transmitter

This block sits at the edge of a transmit baseband path and feeds a high-speed DAC. Each transmit clock cycle it takes one complex sample, as a separate in-phase word and quadrature word, through a valid/ready handshake. It sends that sample over a single 16-bit double-data-rate bus. The in-phase word occupies the high half of the clock period and the quadrature word occupies the low half. A copy of the transmit clock is forwarded beside the data so that the converter can capture source-synchronously.

Both words of a sample are registered together on one rising edge. One more register stage follows, so that both halves of the launched word come from a single register that one edge updates. The half-cycle split is modelled as a multiplexer that the clock level steers. If no sample is offered, the block sends zero, which is mid-scale in two's complement. The frame pin of the converter interface is not needed for word-wide transfers and stays low.

Top module: `ddr_iq_dac_tx`

## Requirements
- R1: While `clk` is high, `dac_data` carries the in-phase word of the launched sample.
- R2: While `clk` is low, `dac_data` carries the quadrature word of the launched sample.
- R3: If a sample is accepted at rising edge k (`in_valid` and `in_ready` both high), its in-phase word is on `dac_data` during the high phase after edge k+1, and its quadrature word follows in the low phase after that. Before edge k+1 the sample is not visible.
- R4: A rising edge at which `in_valid` is low, or at which the sample is not accepted, produces 0 in both halves of the bus one edge later. `in_i` and `in_q` have no effect at such an edge.
- R5: `in_ready` is low after any rising edge at which `rst` is high, and high after any rising edge at which `rst` is low.
- R6: A rising edge at which `rst` is high clears both pipeline stages. The bus then shows 0 in both halves, and samples offered while `rst` is high are dropped.
- R7: `dac_clk` stays low throughout every low phase of `clk`. In the high phase after rising edge m, `dac_clk` is high exactly when `rst` was low at edge m-1, so the clock is silent during reset and comes back cleanly.
- R8: `dac_frame` is always 0.
- R9: Words are passed bit for bit as two's complement, including the extremes 16'h8000 (most negative) and 16'h7FFF (most positive), and I and Q are never swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; also the DDR half selector |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered on in_i / in_q |
| in_ready | output | 1 | Block takes one sample per cycle when high |
| in_i | input | 16 | In-phase word, two's complement |
| in_q | input | 16 | Quadrature word, two's complement |
| dac_data | output | 16 | DDR bus: I in high phase, Q in low phase |
| dac_clk | output | 1 | Forwarded source-synchronous clock |
| dac_frame | output | 1 | Frame strobe, held inactive (0) |

## Verification
The main path is exercised with several kinds of input. A ramp in which the Q word is the bit inverse of the I word exposes any swap of the halves or any off-by-one in the pipeline. Two's-complement extremes and near-zero values catch truncation or sign damage. An isolated single sample, with idle cycles on both sides, pins the latency to exactly one extra edge. Valid patterns that toggle and stay low, with non-zero data left on the inputs, show that unaccepted words never leak onto the bus. A reset issued in the middle of a stream, with valid held high, shows that the pipeline is flushed, the forwarded clock stops and restarts, and the ready signal returns.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    localparam int SAMPLE_W = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t i_word;
        sample_t q_word;
    } iq_pair_t;

    typedef enum logic {
        HALF_Q = 1'b0,
        HALF_I = 1'b1
    } half_sel_t;

    function automatic iq_pair_t iq_zero();
        iq_pair_t z;
        z.i_word = '0;
        z.q_word = '0;
        return z;
    endfunction

    function automatic iq_pair_t iq_make(input sample_t i_w, input sample_t q_w);
        iq_pair_t p;
        p.i_word = i_w;
        p.q_word = q_w;
        return p;
    endfunction

    function automatic sample_t iq_pick(input iq_pair_t p, input half_sel_t h);
        return (h == HALF_I) ? p.i_word : p.q_word;
    endfunction

endpackage

// File: rtl/dac_tx_capture.sv
module dac_tx_capture
    import dac_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  sample_t  in_i,
    input  sample_t  in_q,
    output logic     in_ready,
    output iq_pair_t cap_pair
);

    logic run_q;
    logic take;

    // A sample is taken only when the handshake completes
    assign take     = in_valid && run_q;
    assign in_ready = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    // Same-edge capture: both words registered together; idle inserts mid-scale
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_pair <= iq_zero();
        end else if (take) begin
            cap_pair <= iq_make(in_i, in_q);
        end else begin
            cap_pair <= iq_zero();
        end
    end

endmodule

// File: rtl/dac_tx_launch.sv
module dac_tx_launch
    import dac_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  iq_pair_t cap_pair,
    output iq_pair_t launch_pair
);

    // Second stage: both halves of the output leave from one register
    always_ff @(posedge clk) begin
        if (rst) begin
            launch_pair <= iq_zero();
        end else begin
            launch_pair <= cap_pair;
        end
    end

endmodule

// File: rtl/dac_tx_ddr_mux.sv
module dac_tx_ddr_mux
    import dac_tx_pkg::*;
(
    input  logic     clk,
    input  iq_pair_t launch_pair,
    output sample_t  dac_data
);

    half_sel_t half;

    // Behavioural stand-in for an output DDR cell: clock level picks the half
    assign half     = clk ? HALF_I : HALF_Q;
    assign dac_data = iq_pick(launch_pair, half);

endmodule

// File: rtl/dac_tx_clk_fwd.sv
module dac_tx_clk_fwd (
    input  logic clk,
    input  logic rst,
    output logic dac_clk
);

    logic run_q;
    logic gate_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    // Enable moves only while clk is low, so no runt pulse reaches the pin
    always_ff @(negedge clk) begin
        gate_en <= run_q;
    end

    assign dac_clk = clk & gate_en;

endmodule

// File: rtl/ddr_iq_dac_tx.sv
module ddr_iq_dac_tx
    import dac_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic [SAMPLE_W-1:0] dac_data,
    output logic                dac_clk,
    output logic                dac_frame
);

    iq_pair_t cap_pair;
    iq_pair_t launch_pair;

    dac_tx_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_i     (in_i),
        .in_q     (in_q),
        .in_ready (in_ready),
        .cap_pair (cap_pair)
    );

    dac_tx_launch u_launch (
        .clk         (clk),
        .rst         (rst),
        .cap_pair    (cap_pair),
        .launch_pair (launch_pair)
    );

    dac_tx_ddr_mux u_mux (
        .clk         (clk),
        .launch_pair (launch_pair),
        .dac_data    (dac_data)
    );

    dac_tx_clk_fwd u_clk_fwd (
        .clk     (clk),
        .rst     (rst),
        .dac_clk (dac_clk)
    );

    // Frame strobe is not needed for word-wide transfers
    assign dac_frame = 1'b0;

endmodule

// File: rtl/dac_tx_checker.sv
module dac_tx_checker
    import dac_tx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [SAMPLE_W-1:0] in_q,
    input logic [SAMPLE_W-1:0] dac_data,
    input logic                dac_frame
);

    AST_READY_RUNNING: assert property (@(posedge clk) !rst |=> in_ready); // R5

    AST_READY_HELD_OFF: assert property (@(posedge clk) rst |=> !in_ready); // R5

    AST_Q_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid && in_ready, 2) && !$past(rst, 1) && !$past(rst, 2))
        |-> (dac_data == $past(in_q, 2))); // R3

    AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        ($past(!in_valid && in_ready, 2) && !$past(rst, 1) && !$past(rst, 2))
        |-> (dac_data == '0)); // R4

    AST_FRAME_INACTIVE: assert property (@(posedge clk) dac_frame == 1'b0); // R8

endmodule

bind ddr_iq_dac_tx dac_tx_checker u_dac_tx_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_q      (in_q),
    .dac_data  (dac_data),
    .dac_frame (dac_frame)
);

// File: tb/sim_ddr_iq_dac_tx.sv
module sim_ddr_iq_dac_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        in_ready;
    logic [15:0] dac_data;
    logic        dac_clk;
    logic        dac_frame;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    string tag      = "R6";

    always #10 clk = ~clk;

    ddr_iq_dac_tx u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_i      (in_i),
        .in_q      (in_q),
        .dac_data  (dac_data),
        .dac_clk   (dac_clk),
        .dac_frame (dac_frame)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, tag, $time, act, exp);
        end
    endtask

    // Behavioural reference: a queue of expected words, one per edge
    logic [31:0] pipe[$];
    logic [31:0] exp_word = '0;
    logic        exp_ready = 1'b0;
    logic        prev_run = 1'b0;
    logic        exp_clk_on = 1'b0;
    int          edges = 0;

    always @(posedge clk) begin
        exp_clk_on = prev_run;
        if (rst) begin
            pipe.delete();
            pipe.push_back(32'h0);
            exp_word = 32'h0;
        end else begin
            pipe.push_back((in_valid && exp_ready) ? {in_i, in_q} : 32'h0);
            exp_word = pipe.pop_front();
        end
        exp_ready = !rst;
        prev_run  = !rst;
        edges++;
        if (edges >= 2) begin
            #5;
            check("R1", {16'h0, dac_data}, {16'h0, exp_word[31:16]});
            check("R5", {31'h0, in_ready}, {31'h0, exp_ready});
            check("R7", {31'h0, dac_clk}, {31'h0, exp_clk_on});
            check("R8", {31'h0, dac_frame}, 32'h0);
            #10;
            check("R2", {16'h0, dac_data}, {16'h0, exp_word[15:0]});
            check("R7", {31'h0, dac_clk}, 32'h0);
        end
    end

    task automatic drive(input logic v, input logic [15:0] i_w, input logic [15:0] q_w);
        @(posedge clk);
        #2;
        in_valid = v;
        in_i     = i_w;
        in_q     = q_w;
    endtask

    initial begin
        // Reset with idle inputs
        drive(1'b0, 16'h0, 16'h0);
        drive(1'b0, 16'h0, 16'h0);
        drive(1'b0, 16'h0, 16'h0);
        @(posedge clk);
        #2;
        rst = 1'b0;

        // Idle with non-zero data lingering on the inputs
        tag = "R4";
        for (int k = 0; k < 5; k++) drive(1'b0, 16'h1234 + 16'(k), 16'hBEEF);

        // Isolated sample: explicit latency probe
        tag = "R3";
        drive(1'b1, 16'h5A5A, 16'hA5A5);   // accepted at next edge k
        drive(1'b0, 16'h0, 16'h0);
        #3;                                 // high phase after edge k
        check("R3", {16'h0, dac_data}, 32'h0);
        @(posedge clk);                     // edge k+1
        #5;
        check("R3", {16'h0, dac_data}, 32'h0000_5A5A);
        #10;
        check("R3", {16'h0, dac_data}, 32'h0000_A5A5);
        for (int k = 0; k < 3; k++) drive(1'b0, 16'h7777, 16'h7777);

        // Ramp with Q the inverse of I
        tag = "STREAM";
        for (int k = 0; k < 24; k++) drive(1'b1, 16'(k * 97 + 3), ~16'(k * 97 + 3));

        // Two's complement extremes
        tag = "R9";
        drive(1'b1, 16'h8000, 16'h7FFF);
        drive(1'b1, 16'h7FFF, 16'h8000);
        drive(1'b1, 16'hFFFF, 16'h0001);
        drive(1'b1, 16'h0000, 16'hFFFF);
        drive(1'b1, 16'h8001, 16'h7FFE);

        // Toggling valid
        tag = "R4";
        for (int k = 0; k < 10; k++) drive(k[0], 16'h4000 + 16'(k), 16'hC000 - 16'(k));

        // Reset mid-stream with valid held high
        tag = "R6";
        for (int k = 0; k < 4; k++) drive(1'b1, 16'h1111 * 16'(k + 1), 16'h0F0F);
        @(posedge clk);
        #2;
        rst = 1'b1;
        for (int k = 0; k < 3; k++) drive(1'b1, 16'h6666, 16'h9999);
        @(posedge clk);
        #2;
        rst = 1'b0;
        for (int k = 0; k < 8; k++) drive(1'b1, 16'h2000 + 16'(k), 16'hE000 + 16'(k));
        drive(1'b0, 16'h0, 16'h0);
        for (int k = 0; k < 4; k++) drive(1'b0, 16'h0, 16'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule